// File: doc/BRIEF.md
# Prescaled Multi-Channel Timer Unit

This block collects a configurable number of down-counting timer channels behind one shared 16-bit prescaler. The prescaler counts down on every clock. When it reaches zero it reloads from its reload register and raises a single-cycle tick that all channels see. Each enabled channel steps its 32-bit counter down once per tick. When a tick arrives while the counter is already zero, the channel underflows. It can then raise its own interrupt line and either restart from its reload value or stop.

Software reaches the unit through a simple 32-bit register port with a valid strobe and a write strobe. Writes take effect at the clock edge. Read data is combinational from the address. The first 16 bytes hold the unit registers. Each channel follows in its own 16-byte window. A read-only capability word tells software how many channels are present, which interrupt number the first channel uses, and that every channel has its own interrupt line.

Top module: `mtu_top`

## Requirements
- R1: After reset the prescaler value and prescaler reload read 0, every channel counter, reload and control register reads 0, and every interrupt line is low.
- R2: Address map, using bus_addr[7:2] only: 0x00 prescaler value, 0x04 prescaler reload, 0x08 capability word. Channel n sits at 0x10*(n+1) with counter at +0x0, reload at +0x4 and control at +0x8.
- R3: The prescaler value and reload registers keep only the low 16 bits of write data and read zero in bits 31:16.
- R4: Each clock the prescaler value decrements by one. In a cycle where it is zero, the shared tick is high and the next value is the reload, so ticks come every reload+1 clocks and every clock when the reload is 0. A write to the value register takes priority over the decrement.
- R5: The capability word reads NCH | IRQ_BASE<<3 | 1<<8 | 1<<9, which is 0x342 with the defaults (2 channels, base 8). Writes to it change nothing.
- R6: Reads of offset +0xC in any window, and of windows for channels at or above NCH, return 0. Writes there change no register.
- R7: Channel control bits are: bit0 enable, bit1 auto-restart, bit2 load, bit3 interrupt enable, bit4 pending. Writing bit2 as 1 copies the reload into the counter, and bit2 always reads 0. Writing bit4 as 1 clears pending and writing it as 0 leaves pending unchanged.
- R8: An enabled channel decrements its counter on each tick. A tick with the counter at zero is an underflow. With auto-restart the interrupt period is (reload+1)*(prescaler reload+1) clocks. A write to the channel in the same cycle suppresses that tick's effect on it.
- R9: On an underflow with interrupt enable set, pending becomes 1 and the channel's interrupt line is high for one cycle in the following cycle. Without interrupt enable there is no pulse and pending is not set.
- R10: On an underflow with auto-restart, the counter reloads from the reload register. Without auto-restart, enable clears and the counter wraps to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | NCH | One interrupt pulse line per channel |

## Verification
The assertions take it for granted that at most one register is written per cycle, and that bus_addr and bus_wdata hold known values whenever reset is released. The bench changes the bus only on falling clock edges and drives each write as a single-cycle strobe. It leaves the address on the register it reads back, so the combinational read path is sampled after it settles. The period measurements skip the first interrupt after a channel starts, so the prescaler's phase at start-up does not enter the expected interval.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  localparam int PRESC_W   = 16;
  localparam int CNT_W     = 32;
  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 8;
  localparam int MAX_CH    = 8;

  // register select within a 16-byte window (bus_addr[3:2])
  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_RLD = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;

  // control bit positions
  localparam int B_EN   = 0;
  localparam int B_RST  = 1;
  localparam int B_LOAD = 2;
  localparam int B_IE   = 3;
  localparam int B_PEND = 4;

  function automatic logic [BUS_W-1:0] cap_word(input int n, input int base);
    return BUS_W'(n) | (BUS_W'(base) << 3) | (BUS_W'(1) << 8) | (BUS_W'(1) << 9);
  endfunction
endpackage

// File: rtl/mtu_prescaler.sv
module mtu_prescaler #(
  parameter int W = mtu_pkg::PRESC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_val,
  input  logic         wr_rld,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] val,
  output logic [W-1:0] rld,
  output logic         tick
);
  logic [W-1:0] val_q, rld_q;

  function automatic logic [W-1:0] step(input logic [W-1:0] cur, input logic [W-1:0] re);
    return (cur == '0) ? re : cur - W'(1);
  endfunction

  assign tick = (val_q == '0);
  assign val  = val_q;
  assign rld  = rld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      rld_q <= '0;
    end else begin
      if (wr_rld) rld_q <= wdata;
      if (wr_val) val_q <= wdata;
      else        val_q <= step(val_q, rld_q);
    end
  end

  // R4
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_val) |=> (val_q == $past(rld_q)));
  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_val) |=> (val_q == $past(val_q) - W'(1)));
endmodule

// File: rtl/mtu_channel.sv
module mtu_channel #(
  parameter int CW = mtu_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_cnt,
  input  logic          wr_rld,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rd_cnt,
  output logic [CW-1:0] rd_rld,
  output logic [CW-1:0] rd_ctl,
  output logic          irq
);
  import mtu_pkg::*;

  logic [CW-1:0] cnt_q, rld_q;
  logic en_q, rs_q, ie_q, pend_q, irq_q;
  logic any_wr, step_en, uflow;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic [CW-1:0] r,
                                               input logic restart);
    if (c != '0) return c - CW'(1);
    return restart ? r : '1;
  endfunction

  assign any_wr  = wr_cnt | wr_rld | wr_ctl;
  assign step_en = tick & en_q & ~any_wr;
  assign uflow   = step_en & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      en_q   <= 1'b0;
      rs_q   <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= uflow & ie_q;
      if (wr_rld) rld_q <= wdata;
      if (wr_ctl) begin
        en_q <= wdata[B_EN];
        rs_q <= wdata[B_RST];
        ie_q <= wdata[B_IE];
        if (wdata[B_PEND]) pend_q <= 1'b0;
        if (wdata[B_LOAD]) cnt_q  <= rld_q;
      end
      if (wr_cnt) cnt_q <= wdata;
      if (step_en) cnt_q <= next_count(cnt_q, rld_q, rs_q);
      if (uflow) begin
        if (ie_q)  pend_q <= 1'b1;
        if (!rs_q) en_q   <= 1'b0;
      end
    end
  end

  assign rd_cnt = cnt_q;
  assign rd_rld = rld_q;
  assign rd_ctl = CW'({pend_q, ie_q, 1'b0, rs_q, en_q});
  assign irq    = irq_q;

  // R9
  irq_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> pend_q);
  // R10
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !rs_q) |=> (!en_q && cnt_q == '1));
  // R10
  restart_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && rs_q) |=> (cnt_q == $past(rld_q)));
  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/mtu_top.sv
module mtu_top #(
  parameter int NCH      = 2,
  parameter int IRQ_BASE = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic [mtu_pkg::ADDR_W-1:0] bus_addr,
  input  logic [mtu_pkg::BUS_W-1:0]  bus_wdata,
  output logic [mtu_pkg::BUS_W-1:0]  bus_rdata,
  output logic [NCH-1:0]             irq
);
  import mtu_pkg::*;

  localparam int PW = PRESC_W;
  localparam int CW = CNT_W;
  localparam logic [BUS_W-1:0] CAP = cap_word(NCH, IRQ_BASE);

  logic [3:0] win;
  logic [1:0] rsel;
  logic       wr, unit_hit, ch_hit;
  logic [PW-1:0] p_val, p_rld;
  logic       tick;
  logic [CW-1:0] ch_cnt [NCH];
  logic [CW-1:0] ch_rld [NCH];
  logic [CW-1:0] ch_ctl [NCH];
  logic       unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:PW]};
  assign win      = bus_addr[7:4];
  assign rsel     = bus_addr[3:2];
  assign wr       = bus_valid & bus_write;
  assign unit_hit = (win == 4'd0);
  assign ch_hit   = (win != 4'd0) && (win <= 4'(NCH));

  mtu_prescaler #(.W(PW)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_val (wr & unit_hit & (rsel == SEL_CNT)),
    .wr_rld (wr & unit_hit & (rsel == SEL_RLD)),
    .wdata  (bus_wdata[PW-1:0]),
    .val    (p_val),
    .rld    (p_rld),
    .tick   (tick)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic sel;
    assign sel = wr & ch_hit & (win == 4'(k + 1));
    mtu_channel #(.CW(CW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .wr_cnt (sel & (rsel == SEL_CNT)),
      .wr_rld (sel & (rsel == SEL_RLD)),
      .wr_ctl (sel & (rsel == SEL_CTL)),
      .wdata  (bus_wdata),
      .rd_cnt (ch_cnt[k]),
      .rd_rld (ch_rld[k]),
      .rd_ctl (ch_ctl[k]),
      .irq    (irq[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (unit_hit) begin
      case (rsel)
        SEL_CNT: bus_rdata = BUS_W'(p_val);
        SEL_RLD: bus_rdata = BUS_W'(p_rld);
        SEL_CTL: bus_rdata = CAP;
        default: bus_rdata = '0;
      endcase
    end else if (ch_hit) begin
      for (int k = 0; k < NCH; k++) begin
        if (win == 4'(k + 1)) begin
          case (rsel)
            SEL_CNT: bus_rdata = ch_cnt[k];
            SEL_RLD: bus_rdata = ch_rld[k];
            SEL_CTL: bus_rdata = ch_ctl[k];
            default: bus_rdata = '0;
          endcase
        end
      end
    end
  end

  // R6
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((win > 4'(NCH)) || (rsel == 2'd3)) |-> (bus_rdata == '0));
  // R9
  irq_single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == 1'b0 && $past(tick) == 1'b0 && $past(tick, 2) == 1'b0) |-> (irq == '0));
endmodule

// File: tb/test_mtu_top.sv
`timescale 1ns/1ps
module test_mtu_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0;
  logic bus_write = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mtu_top i_mtu_top (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic period(input int ch, output int p);
    p = 0;
    do @(negedge clk); while (!irq[ch]);
    do begin @(negedge clk); p++; end while (!irq[ch]);
  endtask

  task automatic count_pulses(input int ch, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq[ch]) c++;
    end
  endtask

  // vectors: write flag, address, write data, expected read of the same address
  localparam int NV = 10;
  localparam logic       TV_WE   [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam logic [7:0] TV_ADDR [NV] = '{8'h04, 8'h08, 8'h14, 8'h24, 8'h30,
                                          8'h0C, 8'h1C, 8'h18, 8'h10, 8'h20};
  localparam logic [31:0] TV_WD  [NV] = '{32'h0001_2345, 32'hFFFF_FFFF, 32'h0000_ABCD,
                                          32'h0000_0055, 32'h0000_0077, 32'h0000_0099,
                                          32'h0000_0001, 32'h0000_0006, 32'h0,
                                          32'h0000_1234};
  localparam logic [31:0] TV_EXP [NV] = '{32'h0000_2345, 32'h0000_0342, 32'h0000_ABCD,
                                          32'h0000_0055, 32'h0, 32'h0, 32'h0,
                                          32'h0000_0002, 32'h0000_ABCD, 32'h0000_1234};
  localparam string TV_REQ [NV] = '{"R3", "R5", "R2", "R2", "R6", "R6", "R6",
                                    "R7", "R7", "R2"};

  initial begin
    logic [31:0] d;
    int p, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); chk("R1", d, 32'h0);
    rd(8'h04, d); chk("R1", d, 32'h0);
    rd(8'h10, d); chk("R1", d, 32'h0);
    rd(8'h14, d); chk("R1", d, 32'h0);
    rd(8'h18, d); chk("R1", d, 32'h0);
    rd(8'h28, d); chk("R1", d, 32'h0);
    chk("R1", 32'(irq), 32'h0);
    rd(8'h08, d); chk("R5", d, 32'h0000_0342);

    for (int i = 0; i < NV; i++) begin
      if (TV_WE[i]) wr(TV_ADDR[i], TV_WD[i]);
      rd(TV_ADDR[i], d);
      chk(TV_REQ[i], d, TV_EXP[i]);
    end
    // R6 absent-window write left channel 1 and 0 untouched
    rd(8'h24, d); chk("R6", d, 32'h0000_0055);
    rd(8'h14, d); chk("R6", d, 32'h0000_ABCD);

    // R4 decrement per clock after a value write
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h00, 32'h0000_0100);
    rd(8'h00, d); chk("R4", d, 32'h0000_0100);
    @(negedge clk);
    rd(8'h00, d); chk("R4", d, 32'h0000_00FF);

    // R8 R10 periodic: channel reload 2, prescaler reload 3 -> 12 clocks
    wr(8'h04, 32'h3);
    wr(8'h00, 32'h0);
    wr(8'h14, 32'h2);
    wr(8'h18, 32'h0000_000F);
    period(0, p);
    period(0, p); chk("R8", 32'(p), 32'd12);
    period(0, p); chk("R10", 32'(p), 32'd12);
    @(negedge clk);
    rd(8'h18, d); chk("R9", d, 32'h0000_001B);
    wr(8'h18, 32'h0000_001B);
    rd(8'h18, d); chk("R7", d, 32'h0000_000B);
    wr(8'h18, 32'h0);
    rd(8'h18, d); chk("R7", d, 32'h0);

    // R9 R10 one-shot with interrupt enable
    wr(8'h24, 32'h1);
    wr(8'h28, 32'h0000_000D);
    count_pulses(1, 60, c); chk("R9", 32'(c), 32'd1);
    rd(8'h28, d); chk("R10", d, 32'h0000_0018);
    rd(8'h20, d); chk("R10", d, 32'hFFFF_FFFF);

    // R9 one-shot without interrupt enable, pending cleared by the same write
    wr(8'h28, 32'h0000_0015);
    count_pulses(1, 60, c); chk("R9", 32'(c), 32'd0);
    rd(8'h28, d); chk("R9", d, 32'h0);

    // R4 prescaler reload 0 -> tick every clock; channel reload 4 -> 5 clocks
    wr(8'h04, 32'h0);
    wr(8'h14, 32'h4);
    wr(8'h18, 32'h0000_000F);
    period(0, p);
    period(0, p); chk("R4", 32'(p), 32'd5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule